// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a single-port synchronous static memory with one clock and a shared data path. Every rising edge captures the address, the select, the write enable, the per-lane write enables and the input data. A read issued on one edge shows its word in the output register after the following edge. A write takes its address and controls on one edge and its data on the next. The data waits in a one-entry write buffer and goes into the array on the edge after that.

A read that hits the word still in the buffer gets the buffered lanes merged over the array contents. The caller therefore never sees the one-cycle commit delay. Output enable is a level input that gates the data-bus drive without waiting for a clock.

Each lane is 9 bits wide. Setting `LANES` to 2 with `ADDR_W` of 16 gives a 64K x 18 organization, and setting `LANES` to 4 with `ADDR_W` of 15 gives 32K x 36. The defaults use a shallower array so that elaboration stays small.

Top module: `lw_sram`

## Requirements
- R1: While reset is low and until the first read completes, `dq_oe` is 0 whatever `out_en` is, and no buffered write is pending.
- R2: A read (`sel`=1, `wr_en`=0) captured on edge t puts the addressed word on `dout` with `dq_oe`=1 (given `out_en`=1) after edge t+1, and it stays there until the next read or deselect.
- R3: Write data is taken from `din` on the edge after the write's address edge. The value on `din` at the address edge itself has no effect on the stored word.
- R4: A write changes only the lanes whose `lane_we` bit is 1. Lane i occupies data bits [9i+8:9i], and the other lanes keep their old contents.
- R5: A read of the address written in the directly preceding cycle returns the new data in the written lanes and the previous contents in the other lanes.
- R6: Back-to-back writes to different addresses, interleaved with reads in any order, leave every word holding its last written value.
- R7: `sel`=0 on edge t starts no operation, and `dq_oe` goes to 0 after edge t+1.
- R8: A write cycle leaves `dout` and `dq_oe` as the preceding read or deselect left them.
- R9: `dq_oe` follows `out_en` without a clock edge: `out_en`=0 forces it to 0 at once, and raising `out_en` restores the previous drive state.
- R10: A cycle with `sel`=0 and `wr_en`=1 writes nothing to the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Synchronous select; 0 makes the cycle idle |
| wr_en | input | 1 | Global write enable (1 = write, 0 = read) |
| addr | input | ADDR_W | Word address |
| lane_we | input | LANES | Per-lane write enables for a write |
| din | input | 9*LANES | Write data, one cycle after its write's address |
| out_en | input | 1 | Output enable, level sensitive, unclocked |
| dout | output | 9*LANES | Output register contents |
| dq_oe | output | 1 | Data bus drive enable (0 = high impedance) |

## Verification
A reference memory model predicts every output word. Full-word writes followed by sequential reads establish the basic latency. Partial-lane writes read back in the very next cycle separate correct forwarding from the buffer from stale array data and from whole-word overwrites. Each write's address cycle carries deliberately wrong data on `din`, which catches a design that samples the data on the wrong edge. Deselect cycles with the write enable high, write cycles placed after reads, and a random mix of all three operations show that idle cycles and writes leave both the array and the output register alone.

// File: rtl/lw_sram_pkg.sv
// Shared definitions for the late-write SRAM.
// Assumes lanes of a fixed 9-bit width.
package lw_sram_pkg;
    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } lw_op_e;
endpackage

// File: rtl/lw_cmd_stage.sv
// Input capture stage: registers the select, direction, address and lane
// enables on each rising edge and turns them into an operation code.
// Assumes the controls are synchronous to clk.
module lw_cmd_stage
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we,
    output lw_op_e            op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  lanes_q
);
    // Capture one command per clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_IDLE;
            addr_q  <= '0;
            lanes_q <= '0;
        end else begin
            op_q    <= !sel ? OP_IDLE : (wr_en ? OP_WRITE : OP_READ);
            addr_q  <= addr;
            lanes_q <= lane_we;
        end
    end
endmodule

// File: rtl/lw_write_buffer.sv
// One-entry write buffer. It loads the write data on the edge after a
// write command and offers the entry for commit on the following edge.
// The entry lives one cycle unless a new write replaces it.
// Assumes the array commits whatever is offered while pend_valid is set.
module lw_write_buffer #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int DW     = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LANES-1:0]  load_lanes,
    input  logic [DW-1:0]     load_data,
    output logic              pend_valid,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [LANES-1:0]  pend_lanes,
    output logic [DW-1:0]     pend_data
);
    // Hold the newest write; the old entry is committed on this same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_lanes <= '0;
            pend_data  <= '0;
        end else begin
            pend_valid <= load;
            if (load) begin
                pend_addr  <= load_addr;
                pend_lanes <= load_lanes;
                pend_data  <= load_data;
            end
        end
    end
endmodule

// File: rtl/lw_array.sv
// Storage array, one memory per lane. It has a lane-masked synchronous
// write port and an asynchronous read port.
// Assumes the contents are unknown until written (no reset).
module lw_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES-1:0]        wlanes,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Write this lane when the committed entry enables it.
        always_ff @(posedge clk) begin
            if (we && wlanes[l]) begin
                mem[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/lw_read_out.sv
// Read path: merges the pending buffer over the array word for an
// address match, then loads the output register. Writes leave the
// register alone; idle cycles clear the valid flag.
// Assumes the array read is combinational on the captured address.
module lw_read_out
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  lw_op_e                  op_q,
    input  logic [ADDR_W-1:0]       addr_q,
    input  logic [LANES*LANE_W-1:0] arr_data,
    input  logic                    pend_valid,
    input  logic [ADDR_W-1:0]       pend_addr,
    input  logic [LANES-1:0]        pend_lanes,
    input  logic [LANES*LANE_W-1:0] pend_data,
    output logic [LANES*LANE_W-1:0] q_data,
    output logic                    q_valid
);
    logic                    hit;
    logic [LANES*LANE_W-1:0] merged;

    assign hit = pend_valid && (pend_addr == addr_q);

    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        assign merged[l*LANE_W +: LANE_W] = (hit && pend_lanes[l])
            ? pend_data[l*LANE_W +: LANE_W]
            : arr_data[l*LANE_W +: LANE_W];
    end

    // Output register: load on read, drop valid on idle, hold on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_data  <= '0;
            q_valid <= 1'b0;
        end else begin
            case (op_q)
                OP_READ: begin
                    q_data  <= merged;
                    q_valid <= 1'b1;
                end
                OP_IDLE:  q_valid <= 1'b0;
                default:  q_valid <= q_valid;
            endcase
        end
    end
endmodule

// File: rtl/lw_sram.sv
// Top level of the pipelined late-write SRAM. Built from the command
// stage, write buffer, array and read path. Output enable gates the bus
// drive without any clocking.
// Assumes a single clock and a synchronous active-low reset.
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    localparam int DW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we,
    input  logic [DW-1:0]     din,
    input  logic              out_en,
    output logic [DW-1:0]     dout,
    output logic              dq_oe
);
    lw_op_e            op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  lanes_q;
    logic              pend_valid;
    logic [ADDR_W-1:0] pend_addr;
    logic [LANES-1:0]  pend_lanes;
    logic [DW-1:0]     pend_data;
    logic [DW-1:0]     arr_data;
    logic              rd_valid;

    lw_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
        .addr(addr), .lane_we(lane_we),
        .op_q(op_q), .addr_q(addr_q), .lanes_q(lanes_q)
    );

    lw_write_buffer #(.ADDR_W(ADDR_W), .LANES(LANES), .DW(DW)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .load(op_q == OP_WRITE),
        .load_addr(addr_q), .load_lanes(lanes_q), .load_data(din),
        .pend_valid(pend_valid), .pend_addr(pend_addr),
        .pend_lanes(pend_lanes), .pend_data(pend_data)
    );

    lw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .we(pend_valid), .waddr(pend_addr),
        .wlanes(pend_lanes), .wdata(pend_data),
        .raddr(addr_q), .rdata(arr_data)
    );

    lw_read_out #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .op_q(op_q), .addr_q(addr_q),
        .arr_data(arr_data), .pend_valid(pend_valid),
        .pend_addr(pend_addr), .pend_lanes(pend_lanes),
        .pend_data(pend_data), .q_data(dout), .q_valid(rd_valid)
    );

    assign dq_oe = out_en && rd_valid;
endmodule

// File: rtl/lw_sram_chk.sv
// Assertion checker for lw_sram, attached to it by bind.
// Assumes the top-level signal names of lw_sram.
module lw_sram_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel,
    input logic          wr_en,
    input logic          out_en,
    input logic          dq_oe,
    input logic [DW-1:0] dout,
    input logic          rd_valid,
    input logic          pend_valid
);
    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr_en) |-> ##2 rd_valid); // R2

    AST_DESEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> ##2 !rd_valid); // R7

    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en) |-> ##2 ($stable(dout) && $stable(rd_valid))); // R8

    AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> $past(sel && wr_en, 2)); // R3

    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !dq_oe); // R9

    AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> rd_valid); // R1
endmodule

bind lw_sram lw_sram_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .out_en(out_en),
    .dq_oe(dq_oe), .dout(dout), .rd_valid(rd_valid), .pend_valid(pend_valid)
);

// File: tb/lw_sram_bench.sv
// Scoreboard bench for lw_sram. The driver task applies one command per
// cycle, keeps a reference memory and queues the expected output. A
// monitor compares outputs once each item falls due.
module lw_sram_bench;
    localparam int ADDR_W = 10;
    localparam int LANES  = 2;
    localparam int DW     = 9 * LANES;
    localparam int NADDR  = 16;

    typedef struct {
        int            due;
        bit            valid;
        bit            chk_data;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [LANES-1:0]  lane_we = '0;
    logic [DW-1:0]     din = '0;
    logic              out_en = 1'b1;
    logic [DW-1:0]     dout;
    logic              dq_oe;

    int            total = 0;
    int            bad = 0;
    int            cyc = 0;
    exp_t          sb[$];
    logic [DW-1:0] ref_mem [NADDR];
    logic [DW-1:0] last_out = '0;
    bit            last_valid = 1'b0;
    bit            carry = 1'b0;
    logic [DW-1:0] carry_data = '0;

    lw_sram #(.ADDR_W(ADDR_W), .LANES(LANES)) u_lw_sram (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
        .lane_we(lane_we), .din(din), .out_en(out_en),
        .dout(dout), .dq_oe(dq_oe)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One command cycle. din carries the previous write's data, or the
    // inverse of this write's data as a decoy (R3).
    task automatic step(input bit s, input bit w, input int a,
                        input logic [LANES-1:0] ln, input logic [DW-1:0] wd,
                        input string tag);
        exp_t e;
        @(negedge clk);
        sel = s; wr_en = w; addr = ADDR_W'(a); lane_we = ln;
        din = carry ? carry_data : ~wd;
        carry = s && w;
        carry_data = wd;
        e.due = cyc + 2;
        e.tag = tag;
        if (s && w) begin
            for (int l = 0; l < LANES; l++)
                if (ln[l]) ref_mem[a][l*9 +: 9] = wd[l*9 +: 9];
            e.valid = last_valid; e.chk_data = 1'b1; e.data = last_out;
        end else if (s) begin
            last_out = ref_mem[a]; last_valid = 1'b1;
            e.valid = 1'b1; e.chk_data = 1'b1; e.data = last_out;
        end else begin
            last_valid = 1'b0;
            e.valid = 1'b0; e.chk_data = 1'b0; e.data = '0;
        end
        sb.push_back(e);
    endtask

    task automatic rd(input int a, input string tag);
        step(1'b1, 1'b0, a, '0, '0, tag);
    endtask

    task automatic wr(input int a, input logic [LANES-1:0] ln,
                      input logic [DW-1:0] wd, input string tag);
        step(1'b1, 1'b1, a, ln, wd, tag);
    endtask

    // Monitor: compare outputs for each item that has fallen due.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            if (e.due == cyc) begin
                check(dq_oe == e.valid, {e.tag, " drive"}, DW'(dq_oe), DW'(e.valid));
                if (e.chk_data && e.valid)
                    check(dout == e.data, {e.tag, " data"}, dout, e.data);
            end
        end
    end

    initial begin
        #3000000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] r;
        for (int i = 0; i < NADDR; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        check(dq_oe == 1'b0, "R1 in reset", DW'(dq_oe), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dq_oe == 1'b0, "R1 after reset", DW'(dq_oe), '0);

        // Full-word fill, then sequential reads (R2, R3 decoy data).
        for (int i = 0; i < NADDR; i++) wr(i, '1, DW'(32'h1_0203 * (i + 1)), "R3 fill");
        for (int i = 0; i < NADDR; i++) rd(i, "R2 readback");

        // Partial lane writes read back at once (R4, R5).
        wr(3, 2'b01, 18'h2_AAAA, "R4 low lane"); rd(3, "R5 fwd low");
        wr(4, 2'b10, 18'h1_5555, "R4 high lane"); rd(4, "R5 fwd high");
        wr(5, 2'b00, 18'h3_FFFF, "R4 no lane"); rd(5, "R4 none");
        rd(3, "R4 after commit");

        // Back-to-back writes interleaved with reads (R6).
        wr(6, '1, 18'h0_1111, "R6 w"); wr(7, '1, 18'h0_2222, "R6 w");
        rd(6, "R6 r"); wr(6, 2'b10, 18'h3_3333, "R6 w"); rd(7, "R6 r");
        rd(6, "R6 r");

        // Write cycles after a read keep the output register (R8).
        rd(2, "R8 base"); wr(8, '1, 18'h0_0808, "R8 hold");
        wr(9, '1, 18'h0_0909, "R8 hold");

        // Deselect, also with write enable high (R7, R10).
        step(1'b0, 1'b0, 2, '0, '0, "R7 idle");
        step(1'b0, 1'b1, 10, '1, 18'h3_0000, "R10 idle write");
        step(1'b0, 1'b0, 10, '0, '0, "R7 idle");
        rd(10, "R10 unchanged");
        wr(11, '1, 18'h0_0B0B, "R8 after idle");

        // Output enable acts between edges (R9).
        rd(1, "R9 base");
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0; din = carry ? carry_data : '0; carry = 1'b0;
        last_valid = 1'b0;
        begin
            exp_t e;
            e.due = cyc + 2; e.valid = 1'b0; e.chk_data = 1'b0; e.data = '0; e.tag = "R7 idle";
            sb.push_back(e);
        end
        #2 r = DW'(dq_oe);
        out_en = 1'b0; #1;
        check(dq_oe == 1'b0, "R9 oe low", DW'(dq_oe), '0);
        out_en = 1'b1; #1;
        check(DW'(dq_oe) == r, "R9 oe restore", DW'(dq_oe), r);

        // Random mix against the reference model.
        for (int k = 0; k < 300; k++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 4) wr($urandom_range(0, NADDR - 1), LANES'($urandom),
                           DW'($urandom), "R6 random write");
            else if (op < 9) rd($urandom_range(0, NADDR - 1), "R5 random read");
            else step(1'b0, 1'($urandom), $urandom_range(0, NADDR - 1),
                      '1, DW'($urandom), "R10 random idle");
        end
        for (int i = 0; i < NADDR; i++) rd(i, "R6 final");
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule